// File: doc/BRIEF.md
# Masked-Write GPIO Register with Input-Change Interrupt

This block puts sixteen general-purpose input pins and sixteen general-purpose output pins behind one 32-bit bus word. A read presents the synchronized input pins in the upper half and the output latch in the lower half. A write changes only those output bits whose companion bit in the upper half of the written word is set. Software can therefore set or clear one output without a read-modify-write and without disturbing its neighbours.

The block raises a one-cycle interrupt pulse whenever any synchronized input differs from its value one cycle earlier. Lines 0 and 1 carry a two-wire serial bus: line 0 is data and line 1 is clock. For these two lines the pad is pulled low only when the matching output bit is 0. Otherwise it is released to an external pull-up. The pad level comes back in through the input half, so software can see another device holding the line low. No serial protocol engine is included.

Top module: `gpio_maskreg`

## Requirements
- R1: `rd_data` bits 31:16 hold the synchronized input pins and bits 15:0 hold the current output latch (`gpo`).
- R2: On a cycle with `wr_en` high, output bit n takes `wr_data[n]` when `wr_data[n+16]` is 1 and keeps its value when `wr_data[n+16]` is 0. Writing 0x00010001 sets only output 0, and writing 0x00010000 clears only output 0.
- R3: With `wr_en` low, the output latch holds its value.
- R4: While `rst_n` is low and after it rises, all outputs read 1, both open-drain pull-down enables are 0, the input half reads 0 and `irq` is 0.
- R5: A change on `pin_in` first appears in `rd_data[31:16]` after the second rising clock edge, and not after the first.
- R6: `irq` is high for exactly the cycle in which the synchronized inputs differ from their value one cycle earlier. This is one pulse per change.
- R7: While the inputs stay steady, `irq` stays low.
- R8: `od_low[0]` is 1 exactly when output bit 0 is 0, and `od_low[1]` is 1 exactly when output bit 1 is 0. A value of 1 means the data or clock pad is driven low, and 0 means it is released.
- R9: When output bit 0 or 1 is 1 but the pad is held low externally, the read shows the output bit as 1 and the matching input bit (16 or 17) as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 32 | Write word: change mask in 31:16, new values in 15:0 |
| rd_data | output | 32 | Read word: inputs in 31:16, outputs in 15:0 |
| pin_in | input | 16 | Input pin levels, including the pad levels of lines 0 and 1 |
| gpo | output | 16 | Output latch |
| od_low | output | 2 | Pull-down enables for the data (bit 0) and clock (bit 1) pads |
| irq | output | 1 | Input-change interrupt pulse |

## Verification
The masked write is driven with single-bit set and clear words, a full-mask clear, byte-wide masks, an empty mask carrying all-ones data, and a mask covering only the two open-drain lines. These separate a correct per-bit merge from a latch that ignores the mask, uses the wrong half, or swaps the halves. The input path is driven with one multi-bit step, sampled edge by edge, to tell two-stage timing from one- or three-stage timing and a one-cycle pulse from a level. A pad held low against a released output shows that the input half reflects the pin and not the latch.

// File: rtl/gpio_maskreg.sv
module gpio_maskreg #(
  parameter int NIO = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2*NIO-1:0] wr_data,
  output logic [2*NIO-1:0] rd_data,
  input  logic [NIO-1:0]   pin_in,
  output logic [NIO-1:0]   gpo,
  output logic [1:0]       od_low,
  output logic             irq
);

  logic [NIO-1:0] meta_q, sync_q, prev_q, out_q;
  wire  [NIO-1:0] mask = wr_data[2*NIO-1:NIO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
      out_q  <= '1;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
      if (wr_en)
        out_q <= (out_q & ~mask) | (wr_data[NIO-1:0] & mask);
    end
  end

  assign rd_data = {sync_q, out_q};
  assign gpo     = out_q;
  assign od_low  = ~out_q[1:0];
  assign irq     = |(sync_q ^ prev_q);

  AST_MASKED_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((gpo ^ $past(wr_data[NIO-1:0])) & $past(mask)) == '0); // R2
  AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((gpo ^ $past(gpo)) & ~$past(mask)) == '0); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(gpo)); // R3
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rd_data[2*NIO-1:NIO] != $past(rd_data[2*NIO-1:NIO])); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rd_data[2*NIO-1:NIO]) |-> !irq); // R7
  AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gpo[0]) || $rose(gpo[1]) |-> (od_low & gpo[1:0]) == 2'b00); // R8
  AST_OD_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gpo[0]) |-> od_low[0]); // R8

endmodule

// File: tb/sim_gpio_maskreg.sv
module sim_gpio_maskreg;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [15:0] pin_in = '0;
  logic [15:0] gpo;
  logic [1:0]  od_low;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_maskreg u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .gpo(gpo), .od_low(od_low), .irq(irq));

  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    {32'h0001_0000, 16'hFFFE},
    {32'h0001_0001, 16'hFFFF},
    {32'hFFFF_0000, 16'h0000},
    {32'h00FF_1234, 16'h0034},
    {32'hFF00_ABCD, 16'hAB34},
    {32'h0000_FFFF, 16'hAB34},
    {32'h8001_FFFF, 16'hAB35},
    {32'h0003_FFFC, 16'hAB34}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); step(); step();
    chk("R4 gpo in reset", {16'h0, gpo}, 32'h0000_FFFF);
    chk("R4 od_low in reset", {30'h0, od_low}, 32'h0);
    rst_n = 1;
    step();
    chk("R4 rd_data after reset", rd_data, 32'h0000_FFFF);
    chk("R4 irq after reset", {31'h0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr_en = 1; wr_data = VEC[i][47:16];
      step();
      wr_en = 0; wr_data = 32'hFFFF_FFFF;
      chk("R2 masked write gpo", {16'h0, gpo}, {16'h0, VEC[i][15:0]});
      chk("R1 read low half", {16'h0, rd_data[15:0]}, {16'h0, VEC[i][15:0]});
      chk("R8 open-drain", {30'h0, od_low}, {30'h0, ~VEC[i][1:0]});
      step();
      chk("R3 hold without write", {16'h0, gpo}, {16'h0, VEC[i][15:0]});
    end

    pin_in = 16'h5A5A;
    step();
    chk("R5 not visible after one edge", {16'h0, rd_data[31:16]}, 32'h0);
    chk("R6 no irq yet", {31'h0, irq}, 32'h0);
    step();
    chk("R5 visible after two edges", rd_data, 32'h5A5A_AB34);
    chk("R6 irq pulse", {31'h0, irq}, 32'h1);
    step();
    chk("R6 irq one cycle only", {31'h0, irq}, 32'h0);
    for (int k = 0; k < 10; k++) begin
      step();
      chk("R7 steady inputs quiet", {31'h0, irq}, 32'h0);
    end

    wr_en = 1; wr_data = 32'h0003_0003;
    step();
    wr_en = 0;
    pin_in = 16'h5A58;
    step(); step();
    chk("R9 contention readback", rd_data, 32'h5A58_AB37);
    chk("R8 lines released", {30'h0, od_low}, 32'h0);

    rst_n = 0;
    step();
    chk("R4 reset restores outputs", rd_data, 32'h0000_FFFF);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule